// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the target side of a three-wire serial EEPROM. A host lowers and raises a select line, toggles a shift clock and presents one data bit per rising shift-clock edge. Each instruction is a start bit, a two-bit opcode and an address. The address is six bits long when the wide organization is selected and seven bits long otherwise. The decoded instruction reads a location, writes it, erases it, erases or writes the whole array, or opens or closes the write protection. The storage is a 1024-bit register file. It is organized as 128 bytes or as 64 sixteen-bit words, and both organizations share the same bytes.

All pins are sampled in the system clock domain through a synchronizer of `SYNC_STAGES` flops. Every change to memory starts a self-timed busy period of `PROG_CYCLES` system clocks. A host that deselects and then reselects during that period sees the ready/busy status on the serial output. The serial pins carry no valid/ready handshake and offer no back-pressure. The host paces every transfer with the shift clock, so each shift-clock phase, and each select level, must last at least `SYNC_STAGES + 2` system clocks. The organization input is a static strap and must not change while the block is selected.

Top module: `tw_eeprom`

## Requirements
- R1: After reset, programming is disabled, every storage bit reads 1 and `sout_en_o` is 0.
- R2: After the select rises, zero bits are skipped until a 1 start bit arrives. Two opcode bits follow, MSB first, and then the address, MSB first: 7 bits with `wide_i`=0 and 6 bits with `wide_i`=1. The opcodes are 10 read, 01 write and 11 erase. Opcode 00 takes its meaning from the two top address bits: 11 enables programming, 00 disables it, 10 erases all and 01 writes all. The remaining address bits are don't-care but must still be clocked in.
- R3: A read drives `sout_en_o`=1 and a dummy 0 after the last address bit. Each later rising shift-clock edge presents the next data bit, MSB first: 8 bits narrow, 16 bits wide. A read works whether or not programming is enabled.
- R4: Write, erase, erase-all and write-all change nothing while programming is disabled. The enabled state lasts until a disable instruction or a reset.
- R5: A write stores the 8 or 16 data bits that follow the address, with no prior erase needed. Wide word n is held in bytes 2n (upper half) and 2n+1 (lower half).
- R6: Erase sets the addressed location to all ones. Erase-all sets every byte to 0xFF.
- R7: Write-all stores the supplied pattern in every location.
- R8: An accepted change starts a busy period of exactly `PROG_CYCLES` system clocks. It starts after the last data bit of a write or write-all, and after the last address bit of an erase or erase-all. A select raised while busy gives `sout_en_o`=1, with `sout_o`=0 while busy and 1 once ready, until the select falls.
- R9: A select raised after the busy period has ended shows no status (`sout_en_o`=0).
- R10: Input received during a status phase, including a complete instruction, is ignored.
- R11: A select that falls before an instruction is complete aborts it, leaves memory unchanged and starts no busy period.
- R12: `sout_en_o` is 0 whenever the select is low and outside the read and status phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Chip select, active high |
| shclk_i | input | 1 | Serial shift clock from the host |
| sin_i | input | 1 | Serial data from the host |
| wide_i | input | 1 | Organization strap: 1 selects 64x16, 0 selects 128x8 |
| sout_o | output | 1 | Serial data or ready/busy status |
| sout_en_o | output | 1 | Output enable for `sout_o` (low means high impedance) |

## Verification
The bench builds the block with `PROG_CYCLES`=40, `SYNC_STAGES`=2 and the default 7-bit byte address. This short busy period lets one select window see the status go from busy to ready. It also lets a complete instruction, sent during a status phase, run past the end of the busy period, which tests that input is still ignored after the block becomes ready. Both organizations are used against the same array, so the byte mapping of wide words is checked at the pins.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // deselected
    ST_START,  // waiting for start bit
    ST_OPC,    // shifting opcode
    ST_ADDR,   // shifting address
    ST_DATA,   // shifting write data
    ST_RDOUT,  // driving read data
    ST_STAT,   // driving ready/busy
    ST_DONE    // instruction finished, waiting for deselect
  } tw_state_e;

  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_ERASE   = 2'b11;

  localparam logic [1:0] SP_LOCK    = 2'b00;
  localparam logic [1:0] SP_FILL    = 2'b01;
  localparam logic [1:0] SP_WIPE    = 2'b10;
  localparam logic [1:0] SP_UNLOCK  = 2'b11;

endpackage

// File: rtl/tw_pin_sync.sv
module tw_pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign lvl_o = chain[STAGES-1];

endmodule

// File: rtl/tw_prog_timer.sv
module tw_prog_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain_q <= '0;
    else if (start_i)          remain_q <= CW'(CYCLES);
    else if (remain_q != '0)   remain_q <= remain_q - CW'(1);
  end

  assign busy_o = (remain_q != '0);

endmodule

// File: rtl/tw_store.sv
module tw_store #(
  parameter int BYTE_AW = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic               all_i,
  input  logic               wide_i,
  input  logic [BYTE_AW-1:0] waddr_i,
  input  logic [15:0]        wdata_i,
  input  logic [BYTE_AW-1:0] raddr_i,
  output logic [7:0]         rhi_o,
  output logic [7:0]         rlo_o
);

  localparam int NB = 1 << BYTE_AW;

  logic [7:0] mem [NB];

  generate
    for (genvar i = 0; i < NB; i++) begin : g_byte
      localparam logic [BYTE_AW-1:0] IDX = BYTE_AW'(i);
      logic       hit;
      logic [7:0] val;
      assign hit = all_i | (wide_i ? (IDX[BYTE_AW-1:1] == waddr_i[BYTE_AW-1:1])
                                   : (IDX == waddr_i));
      assign val = (wide_i && !IDX[0]) ? wdata_i[15:8] : wdata_i[7:0];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          mem[i] <= 8'hFF;
        else if (we_i && hit) mem[i] <= val;
      end
    end
  endgenerate

  assign rhi_o = mem[raddr_i];
  assign rlo_o = mem[{raddr_i[BYTE_AW-1:1], 1'b1}];

endmodule

// File: rtl/tw_eeprom.sv
module tw_eeprom
  import tw_eeprom_pkg::*;
#(
  parameter int BYTE_AW     = 7,
  parameter int PROG_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic shclk_i,
  input  logic sin_i,
  input  logic wide_i,
  output logic sout_o,
  output logic sout_en_o
);

  localparam int WORD_AW = BYTE_AW - 1;
  localparam int CNT_W   = $clog2(16 + 1);

  // ---------------- pin sampling ----------------
  logic [2:0] pins_s;
  logic       sel_s, clk_s, sin_s;
  logic [1:0] prev_q;
  logic       sel_rise, sel_fall, sh_rise;

  tw_pin_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i ({sel_i, shclk_i, sin_i}),
    .lvl_o (pins_s)
  );

  assign {sel_s, clk_s, sin_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= {sel_s, clk_s};
  end

  assign sel_rise = sel_s & ~prev_q[1];
  assign sel_fall = ~sel_s & prev_q[1];
  assign sh_rise  = clk_s & ~prev_q[0] & sel_s;

  // ---------------- state ----------------
  tw_state_e          st_q, st_d;
  logic [1:0]         opc_q, opc_d;
  logic [BYTE_AW-1:0] addr_q, addr_d;
  logic [15:0]        dat_q, dat_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [16:0]        out_q, out_d;
  logic               en_q, en_d;

  logic               busy;
  logic               mem_we, mem_all;
  logic [15:0]        mem_wdata;
  logic [BYTE_AW-1:0] mem_waddr;
  logic [7:0]         rd_hi, rd_lo;

  // ---------------- derived values ----------------
  logic [CNT_W-1:0]   addr_len, data_len;
  logic [BYTE_AW-1:0] addr_nx, ba_nx, ba_q;
  logic [15:0]        dat_nx;
  logic [1:0]         top2;

  assign addr_len = wide_i ? CNT_W'(WORD_AW) : CNT_W'(BYTE_AW);
  assign data_len = wide_i ? CNT_W'(16) : CNT_W'(8);
  assign addr_nx  = {addr_q[BYTE_AW-2:0], sin_s};
  assign dat_nx   = {dat_q[14:0], sin_s};
  assign top2     = wide_i ? addr_nx[WORD_AW-1 -: 2] : addr_nx[BYTE_AW-1 -: 2];
  assign ba_nx    = wide_i ? {addr_nx[WORD_AW-1:0], 1'b0} : addr_nx;
  assign ba_q     = wide_i ? {addr_q[WORD_AW-1:0], 1'b0} : addr_q;

  // ---------------- next-state logic ----------------
  always_comb begin
    st_d      = st_q;
    opc_d     = opc_q;
    addr_d    = addr_q;
    dat_d     = dat_q;
    cnt_d     = cnt_q;
    out_d     = out_q;
    en_d      = en_q;
    mem_we    = 1'b0;
    mem_all   = 1'b0;
    mem_wdata = dat_nx;
    mem_waddr = ba_q;

    if (sel_fall) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (sel_rise) st_d = busy ? ST_STAT : ST_START;
        end
        ST_START: begin
          if (sh_rise && sin_s) begin
            st_d  = ST_OPC;
            cnt_d = '0;
          end
        end
        ST_OPC: begin
          if (sh_rise) begin
            opc_d = {opc_q[0], sin_s};
            if (cnt_q == CNT_W'(1)) begin
              st_d  = ST_ADDR;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_ADDR: begin
          if (sh_rise) begin
            addr_d = addr_nx;
            if (cnt_q == addr_len - CNT_W'(1)) begin
              cnt_d = '0;
              case (opc_q)
                OP_READ: begin
                  st_d  = ST_RDOUT;
                  out_d = wide_i ? {1'b0, rd_hi, rd_lo} : {1'b0, rd_hi, 8'h00};
                  cnt_d = data_len;
                end
                OP_WRITE: st_d = ST_DATA;
                OP_ERASE: begin
                  st_d      = ST_DONE;
                  mem_we    = en_q;
                  mem_wdata = '1;
                  mem_waddr = ba_nx;
                end
                default: begin
                  st_d = ST_DONE;
                  case (top2)
                    SP_UNLOCK: en_d = 1'b1;
                    SP_LOCK:   en_d = 1'b0;
                    SP_WIPE: begin
                      mem_we    = en_q;
                      mem_all   = 1'b1;
                      mem_wdata = '1;
                    end
                    default:   st_d = ST_DATA;
                  endcase
                end
              endcase
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_DATA: begin
          if (sh_rise) begin
            dat_d = dat_nx;
            if (cnt_q == data_len - CNT_W'(1)) begin
              st_d    = ST_DONE;
              mem_we  = en_q;
              mem_all = (opc_q == OP_SPECIAL);
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_RDOUT: begin
          if (sh_rise) begin
            if (cnt_q == '0) begin
              st_d = ST_DONE;
            end else begin
              out_d = {out_q[15:0], 1'b0};
              cnt_d = cnt_q - CNT_W'(1);
            end
          end
        end
        ST_STAT: ;
        ST_DONE: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      opc_q  <= '0;
      addr_q <= '0;
      dat_q  <= '0;
      cnt_q  <= '0;
      out_q  <= '0;
      en_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      opc_q  <= opc_d;
      addr_q <= addr_d;
      dat_q  <= dat_d;
      cnt_q  <= cnt_d;
      out_q  <= out_d;
      en_q   <= en_d;
    end
  end

  // ---------------- storage and timer ----------------
  tw_store #(.BYTE_AW(BYTE_AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mem_we),
    .all_i   (mem_all),
    .wide_i  (wide_i),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (ba_nx),
    .rhi_o   (rd_hi),
    .rlo_o   (rd_lo)
  );

  tw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (mem_we),
    .busy_o  (busy)
  );

  // ---------------- serial output ----------------
  logic rd_phase, stat_phase;
  assign rd_phase   = (st_q == ST_RDOUT);
  assign stat_phase = (st_q == ST_STAT);
  assign sout_en_o  = rd_phase | stat_phase;
  assign sout_o     = stat_phase ? ~busy : (rd_phase & out_q[16]);

endmodule

// File: rtl/tw_eeprom_chk.sv
module tw_eeprom_chk #(
  parameter int PROG_CYCLES = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic sel_s,
  input logic busy,
  input logic mem_we,
  input logic prog_en,
  input logic rd_phase,
  input logic sout_o,
  input logic sout_en_o
);

  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  // R4: memory changes only with programming enabled
  a_r4_we_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> prog_en);

  // R10: no change is accepted while a cycle runs
  a_r10_no_we_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !busy);

  // R8: busy follows every accepted change
  a_r8_busy_after_we: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> busy);

  // R8: busy period length
  a_r8_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == PROG_CYCLES));

  // R12: output released after deselect
  a_r12_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> !sout_en_o);

  // R3: read phase opens with the dummy zero
  a_r3_dummy_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sout_en_o) && rd_phase) |-> !sout_o);

endmodule

bind tw_eeprom tw_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_s     (sel_s),
  .busy      (busy),
  .mem_we    (mem_we),
  .prog_en   (en_q),
  .rd_phase  (rd_phase),
  .sout_o    (sout_o),
  .sout_en_o (sout_en_o)
);

// File: tb/sim_tw_eeprom.sv
module sim_tw_eeprom;

  localparam int CLK_PERIOD = 10;
  localparam int PROG       = 40;
  localparam int HALF       = 4;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, shclk = 1'b0, sin = 1'b0, wide = 1'b0;
  logic sout, sout_en;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_eeprom #(.BYTE_AW(7), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .shclk_i(shclk), .sin_i(sin),
    .wide_i(wide), .sout_o(sout), .sout_en_o(sout_en)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_bit(input logic b);
    @(negedge clk); sin = b;
    wait_clk(HALF);
    shclk = 1'b1;
    wait_clk(HALF);
    shclk = 1'b0;
  endtask

  task automatic sel_on;
    @(negedge clk); sel = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic sel_off;
    @(negedge clk); sel = 1'b0; sin = 1'b0;
    wait_clk(HALF + 2);
  endtask

  task automatic instr(input logic [1:0] op, input logic [6:0] addr);
    int nb = wide ? 6 : 7;
    sk_bit(1'b1);
    sk_bit(op[1]);
    sk_bit(op[0]);
    for (int i = nb - 1; i >= 0; i--) sk_bit(addr[i]);
  endtask

  task automatic send_data(input logic [15:0] d);
    int nd = wide ? 16 : 8;
    for (int i = nd - 1; i >= 0; i--) sk_bit(d[i]);
  endtask

  function automatic logic [6:0] spec_addr(input logic [1:0] code);
    return wide ? {1'b0, code, 4'b0000} : {code, 5'b00000};
  endfunction

  task automatic wait_done;
    wait_clk(PROG + 10);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [15:0] d);
    sel_on; instr(2'b01, a); send_data(d); sel_off;
  endtask

  task automatic do_special(input logic [1:0] code);
    sel_on; instr(2'b00, spec_addr(code)); sel_off;
  endtask

  task automatic do_read(input logic [6:0] a, input logic [15:0] exp, input string req, input bit lead0);
    logic [15:0] v = '0;
    int nd = wide ? 16 : 8;
    sel_on;
    if (lead0) sk_bit(1'b0);
    instr(2'b10, a);
    chk(sout_en === 1'b1 && sout === 1'b0, {req, " R3 dummy bit"}, {14'd0, sout_en, sout}, 16'h0002);
    for (int i = nd - 1; i >= 0; i--) begin
      sk_bit(1'b0);
      v[i] = sout;
    end
    chk(v === exp, req, v, exp);
    sel_off;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk(sout_en === 1'b0, "R1 output idle after reset", {15'd0, sout_en}, 16'h0);
    wide = 1'b0;
    do_read(7'd5, 16'h00FF, "R1 R3 erased byte readable while locked", 1'b0);
    chk(sout_en === 1'b0, "R12 released after read", {15'd0, sout_en}, 16'h0);
  endtask

  task automatic t_locked;
    do_write(7'd3, 16'h005A);
    sel_on;
    chk(sout_en === 1'b0, "R4 no cycle started while locked", {15'd0, sout_en}, 16'h0);
    sel_off;
    do_read(7'd3, 16'h00FF, "R4 write ignored while locked", 1'b0);
  endtask

  task automatic t_write_status;
    do_special(2'b11);
    do_write(7'd3, 16'h005A);
    sel_on;
    chk(sout_en === 1'b1 && sout === 1'b0, "R8 busy status", {14'd0, sout_en, sout}, 16'h0002);
    wait_clk(PROG + 5);
    chk(sout_en === 1'b1 && sout === 1'b1, "R8 ready status", {14'd0, sout_en, sout}, 16'h0003);
    sel_off;
    chk(sout_en === 1'b0, "R12 released after status", {15'd0, sout_en}, 16'h0);
    sel_on;
    chk(sout_en === 1'b0, "R9 no status after cycle ended", {15'd0, sout_en}, 16'h0);
    sel_off;
    do_read(7'd3, 16'h005A, "R5 byte write", 1'b0);
    do_write(7'd3, 16'h00A5); wait_done;
    do_read(7'd3, 16'h00A5, "R5 overwrite without erase", 1'b0);
  endtask

  task automatic t_wide;
    wide = 1'b1;
    do_write(7'd2, 16'h1234); wait_done;
    do_read(7'd2, 16'h1234, "R5 R2 wide word write, leading zero skipped", 1'b1);
    wide = 1'b0;
    do_read(7'd4, 16'h0012, "R5 wide word upper byte at 2n", 1'b0);
    do_read(7'd5, 16'h0034, "R5 wide word lower byte at 2n+1", 1'b0);
  endtask

  task automatic t_erase;
    sel_on; instr(2'b11, 7'd3); sel_off; wait_done;
    do_read(7'd3, 16'h00FF, "R6 erase one byte", 1'b0);
  endtask

  task automatic t_busy_ignore;
    do_write(7'd10, 16'h0011);
    sel_on;
    instr(2'b01, 7'd11); send_data(16'h0022);
    chk(sout_en === 1'b1 && sout === 1'b1, "R10 status kept through ignored input", {14'd0, sout_en, sout}, 16'h0003);
    sel_off; wait_done;
    do_read(7'd11, 16'h00FF, "R10 instruction during status ignored", 1'b0);
    do_read(7'd10, 16'h0011, "R10 first write kept", 1'b0);
  endtask

  task automatic t_abort;
    sel_on; instr(2'b01, 7'd12);
    for (int i = 0; i < 4; i++) sk_bit(1'b0);
    sel_off;
    sel_on;
    chk(sout_en === 1'b0, "R11 aborted write starts no cycle", {15'd0, sout_en}, 16'h0);
    sel_off;
    do_read(7'd12, 16'h00FF, "R11 aborted write leaves memory", 1'b0);
  endtask

  task automatic t_all;
    wide = 1'b1;
    sel_on; instr(2'b00, spec_addr(2'b01)); send_data(16'hBEEF); sel_off; wait_done;
    do_read(7'd0,  16'hBEEF, "R7 write-all first word", 1'b0);
    do_read(7'd63, 16'hBEEF, "R7 write-all last word", 1'b0);
    wide = 1'b0;
    do_read(7'd10, 16'h00BE, "R7 write-all seen as bytes", 1'b0);
    sel_on; instr(2'b00, spec_addr(2'b10)); sel_off; wait_done;
    do_read(7'd0,   16'h00FF, "R6 erase-all first byte", 1'b0);
    do_read(7'd127, 16'h00FF, "R6 erase-all last byte", 1'b0);
  endtask

  task automatic t_lock_and_reset;
    do_special(2'b00);
    do_write(7'd7, 16'h0000); wait_done;
    do_read(7'd7, 16'h00FF, "R4 disable blocks write", 1'b0);
    do_special(2'b11);
    do_write(7'd1, 16'h0033); wait_done;
    do_read(7'd1, 16'h0033, "R4 re-enabled write", 1'b0);
    @(negedge clk); rst_n = 1'b0; wait_clk(3); rst_n = 1'b1; wait_clk(3);
    chk(sout_en === 1'b0, "R1 output idle after second reset", {15'd0, sout_en}, 16'h0);
    do_read(7'd1, 16'h00FF, "R1 array all ones after reset", 1'b0);
    do_write(7'd1, 16'h0044); wait_done;
    do_read(7'd1, 16'h00FF, "R4 reset returns to locked", 1'b0);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset;
    t_locked;
    t_write_status;
    t_wide;
    t_erase;
    t_busy_ignore;
    t_abort;
    t_all;
    t_lock_and_reset;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule